// File: doc/BRIEF.md
# PWM Dead-Time Inserter with Atomic Delay Commit

This block sits between a ramp generator and a power-stage driver. The ramp generator sends two one-cycle edge strobes per switching period: a cycle-start strobe (t1) and a mid-cycle strobe (t2). The block turns them into a single PWM level. The rising edge of that level is held back by a programmable rise delay, counted from one strobe. The falling edge is held back by a separate fall delay, counted from the other strobe. A select input chooses which strobe anchors the rising edge.

Delay values are written through a small register port into shadow copies, so a partial update never reaches the output. Writing a designated commit address copies every shadow value into the active set on one clock edge. Each cycle-start strobe then latches the active set as the in-use set for that ramp cycle. A commit that lands mid-cycle therefore first shapes the output at the next cycle start. All delays count clock ticks, the same unit as the ramp timer.

Top module: `dt_inserter`

## Requirements
- R1: After reset, `pwm_out` is 0 and the shadow, active and in-use delays are all 0, so the first ramp cycle passes both edges through undelayed.
- R2: With `rise_sel`=0 the output rises rise-delay ticks after the t1 strobe. With `rise_sel`=1 it rises rise-delay ticks after the t2 strobe.
- R3: The output falls fall-delay ticks after whichever strobe does not anchor the rising edge: t2 when `rise_sel`=0, t1 when `rise_sel`=1.
- R4: A strobe sampled on clock edge k with a delay of D changes `pwm_out` on edge k+D. A delay of 0 changes the output on the same edge that samples the strobe.
- R5: A write to address 0 (rise) or address 1 (fall) loads bits [15:8] of `wr_data` into that shadow value only, and the other bits are ignored. The output timing does not change until a commit.
- R6: A write to address 2 (commit) copies both shadow delays into the active delays on the same clock edge. The data of a commit write is ignored.
- R7: Each t1 strobe latches the active delays as the in-use delays for that ramp cycle. A t1-anchored edge uses the active values, and a t2-anchored edge uses the in-use values. A commit made between t1 and t2 therefore takes effect from the next t1.
- R8: When the rise and fall delays expire on the same clock edge, the output is driven low.
- R9: Between expiries the output holds its level. Delays up to 2^DLY_W-1 ticks (255 by default) are timed exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of every delay |
| rst | input | 1 | Synchronous active-high reset |
| t1_evt | input | 1 | Cycle-start edge strobe, one cycle wide |
| t2_evt | input | 1 | Mid-cycle edge strobe, one cycle wide |
| rise_sel | input | 1 | 0: rise anchored to t1, fall to t2; 1: the reverse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 rise shadow, 1 fall shadow, 2 commit |
| wr_data | input | CMD_W | Write data; the delay byte is the top DLY_W bits |
| pwm_out | output | 1 | Registered PWM level with dead times applied |

## Verification
The bench builds the block with its default parameters: 8-bit delays, a 16-bit command word and a 2-bit address. With these values the delay byte sits at bits [15:8], and stray low-byte data shows that those bits are discarded. The 8-bit width also allows a full 255-tick rise delay to be timed inside a single 320-cycle ramp, next to zero-delay pass-through and short delays on both strobe mappings. The bench also places a commit between t1 and t2 to show when new values take effect, and tunes the rise and fall delays so that both expire on the same edge.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Index of each edge timer in the timer array
  localparam int IDX_RISE = 0;
  localparam int IDX_FALL = 1;
  localparam int N_EDGES  = 2;
endpackage

// File: rtl/dt_shadow_bank.sv
// Three-stage delay storage: shadow (written by software), active
// (loaded on commit), in-use (loaded at each ramp-cycle start).
module dt_shadow_bank #(
  parameter int DLY_W    = 8,
  parameter int CMD_W    = 16,
  parameter int ADDR_W   = 2,
  parameter int A_RISE   = 0,
  parameter int A_FALL   = 1,
  parameter int A_COMMIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              cyc_start,
  output logic [DLY_W-1:0]  shd_rise,
  output logic [DLY_W-1:0]  shd_fall,
  output logic [DLY_W-1:0]  act_rise,
  output logic [DLY_W-1:0]  act_fall,
  output logic [DLY_W-1:0]  use_rise,
  output logic [DLY_W-1:0]  use_fall
);
  localparam int BYTE_LSB = CMD_W - DLY_W;

  logic             hit_rise, hit_fall, hit_commit;
  logic [DLY_W-1:0] wr_dly;

  always_comb begin
    wr_dly     = wr_data[CMD_W-1:BYTE_LSB];
    hit_rise   = wr_en && (wr_addr == ADDR_W'(A_RISE));
    hit_fall   = wr_en && (wr_addr == ADDR_W'(A_FALL));
    hit_commit = wr_en && (wr_addr == ADDR_W'(A_COMMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_rise <= '0;
      shd_fall <= '0;
      act_rise <= '0;
      act_fall <= '0;
      use_rise <= '0;
      use_fall <= '0;
    end else begin
      if (hit_rise) shd_rise <= wr_dly;
      if (hit_fall) shd_fall <= wr_dly;
      if (hit_commit) begin
        act_rise <= shd_rise;
        act_fall <= shd_fall;
      end
      if (cyc_start) begin
        use_rise <= act_rise;
        use_fall <= act_fall;
      end
    end
  end
endmodule

// File: rtl/dt_edge_timer.sv
// Down-counter that reports when a delayed edge is due. A trigger
// restarts the count; a zero delay fires in the trigger cycle itself.
module dt_edge_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (trig) begin
      cnt <= dly;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  always_comb begin
    if (trig) fire = (dly == '0);
    else      fire = (cnt == ONE);
  end
endmodule

// File: rtl/dt_inserter.sv
module dt_inserter #(
  parameter int DLY_W    = 8,
  parameter int CMD_W    = 16,
  parameter int ADDR_W   = 2,
  parameter int A_RISE   = 0,
  parameter int A_FALL   = 1,
  parameter int A_COMMIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              t1_evt,
  input  logic              t2_evt,
  input  logic              rise_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output logic              pwm_out
);
  import dt_pkg::*;

  logic [DLY_W-1:0]   shd_rise, shd_fall;
  logic [DLY_W-1:0]   act_rise, act_fall;
  logic [DLY_W-1:0]   use_rise, use_fall;
  logic [N_EDGES-1:0] trig;
  logic [N_EDGES-1:0] fire;
  logic [DLY_W-1:0]   dly [N_EDGES];

  dt_shadow_bank #(
    .DLY_W(DLY_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W),
    .A_RISE(A_RISE), .A_FALL(A_FALL), .A_COMMIT(A_COMMIT)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cyc_start(t1_evt),
    .shd_rise (shd_rise),
    .shd_fall (shd_fall),
    .act_rise (act_rise),
    .act_fall (act_fall),
    .use_rise (use_rise),
    .use_fall (use_fall)
  );

  // t1-anchored edges take the active set (it is latched as in-use on
  // this same strobe); t2-anchored edges take the in-use set.
  always_comb begin
    trig[IDX_RISE] = rise_sel ? t2_evt : t1_evt;
    trig[IDX_FALL] = rise_sel ? t1_evt : t2_evt;
    dly[IDX_RISE]  = rise_sel ? use_rise : act_rise;
    dly[IDX_FALL]  = rise_sel ? act_fall : use_fall;
  end

  for (genvar g = 0; g < N_EDGES; g++) begin : g_tmr
    dt_edge_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk (clk),
      .rst (rst),
      .trig(trig[g]),
      .dly (dly[g]),
      .fire(fire[g])
    );
  end

  // Turn-off has priority over turn-on
  always_ff @(posedge clk) begin
    if (rst)                 pwm_out <= 1'b0;
    else if (fire[IDX_FALL]) pwm_out <= 1'b0;
    else if (fire[IDX_RISE]) pwm_out <= 1'b1;
  end
endmodule

// File: rtl/dt_inserter_chk.sv
module dt_inserter_chk #(
  parameter int DLY_W    = 8,
  parameter int ADDR_W   = 2,
  parameter int A_COMMIT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              t1_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DLY_W-1:0]  shd_rise,
  input logic [DLY_W-1:0]  shd_fall,
  input logic [DLY_W-1:0]  act_rise,
  input logic [DLY_W-1:0]  act_fall,
  input logic [DLY_W-1:0]  use_rise,
  input logic [DLY_W-1:0]  use_fall,
  input logic              rise_fire,
  input logic              fall_fire,
  input logic              pwm_out
);
  logic commit_wr;
  assign commit_wr = wr_en && (wr_addr == ADDR_W'(A_COMMIT));

  a_r5_no_commit_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_wr |=> ($stable(act_rise) && $stable(act_fall)));

  a_r6_commit_copies: assert property (@(posedge clk) disable iff (rst)
    commit_wr |=> (act_rise == $past(shd_rise) && act_fall == $past(shd_fall)));

  a_r7_inuse_latch: assert property (@(posedge clk) disable iff (rst)
    t1_evt |=> (use_rise == $past(act_rise) && use_fall == $past(act_fall)));

  a_r7_inuse_hold: assert property (@(posedge clk) disable iff (rst)
    !t1_evt |=> ($stable(use_rise) && $stable(use_fall)));

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
    (rise_fire && !fall_fire) |=> pwm_out);

  a_r8_off_wins: assert property (@(posedge clk) disable iff (rst)
    fall_fire |=> !pwm_out);

  a_r9_level_hold: assert property (@(posedge clk) disable iff (rst)
    (!rise_fire && !fall_fire) |=> $stable(pwm_out));
endmodule

bind dt_inserter dt_inserter_chk #(
  .DLY_W(DLY_W), .ADDR_W(ADDR_W), .A_COMMIT(A_COMMIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .t1_evt   (t1_evt),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .shd_rise (shd_rise),
  .shd_fall (shd_fall),
  .act_rise (act_rise),
  .act_fall (act_fall),
  .use_rise (use_rise),
  .use_fall (use_fall),
  .rise_fire(fire[0]),
  .fall_fire(fire[1]),
  .pwm_out  (pwm_out)
);

// File: tb/test_dt_inserter.sv
module test_dt_inserter;
  localparam int DLY_W  = 8;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              t1_evt = 1'b0;
  logic              t2_evt = 1'b0;
  logic              rise_sel = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CMD_W-1:0]  wr_data = '0;
  logic              pwm_out;

  dt_inserter #(.DLY_W(DLY_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W)) i_dt_inserter (
    .clk(clk), .rst(rst), .t1_evt(t1_evt), .t2_evt(t2_evt),
    .rise_sel(rise_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;  // 4 ns period

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  int n_run  = 0;
  int n_fail = 0;
  int sh_r = 0, sh_f = 0, act_r = 0, act_f = 0;
  bit lvl = 1'b0;

  task automatic check(input bit got, input bit exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0b expected %0b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic push(input int at, input bit v, input string tag);
    if (at > cyc) sb.push_back('{at, v, tag});
  endtask

  // Monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        check(pwm_out, sb[i].val, sb[i].tag);
        sb.delete(i);
      end
    end
  end

  task automatic wr(input int a, input logic [CMD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) sh_r = int'(d[CMD_W-1:CMD_W-DLY_W]);
    if (a == 1) sh_f = int'(d[CMD_W-1:CMD_W-DLY_W]);
    if (a == 2) begin act_r = sh_r; act_f = sh_f; end
  endtask

  // One ramp cycle of len ticks; t2 at offset t2off; optional commit at cm
  task automatic ramp(input bit s, input int t2off, input int len, input int cm,
                      input string tag_r, input string tag_f);
    int c0, t1e, t2e, r, f;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        c0  = cyc;
        t1e = c0 + 1;
        t2e = c0 + t2off + 1;
        if (!s) begin
          r = t1e + act_r; f = t2e + act_f;
          if (r == f) begin
            push(r - 1, 1'b0, tag_f); push(r, 1'b0, tag_f); push(r + 1, 1'b0, tag_f);
          end else begin
            push(r - 1, lvl, tag_r); push(r, 1'b1, tag_r);
            push(f - 1, 1'b1, tag_f); push(f, 1'b0, tag_f);
          end
          lvl = 1'b0;
        end else begin
          f = t1e + act_f; r = t2e + act_r;
          push(f - 1, lvl, tag_f); push(f, 1'b0, tag_f);
          push(r - 1, 1'b0, tag_r); push(r, 1'b1, tag_r);
          lvl = 1'b1;
        end
      end
      rise_sel = s;
      t1_evt   = (i == 0);
      t2_evt   = (i == t2off);
      if (i == cm) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h5A5A;
      end else begin
        wr_en = 1'b0;
      end
    end
    if (cm >= 0) begin act_r = sh_r; act_f = sh_f; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pwm_out, 1'b0, "R1 reset level");
    rst = 1'b0;

    ramp(1'b0, 20, 40, -1, "R1 R4 zero-delay rise", "R1 R4 zero-delay fall");

    wr(0, 16'h03A7); wr(1, 16'h0511); wr(2, 16'hFFFF);
    ramp(1'b0, 20, 40, -1, "R2 R4 rise after t1", "R3 fall after t2");
    ramp(1'b1, 20, 40, -1, "R2 rise after t2", "R3 fall after t1");

    // Shadow writes with low-byte noise, no commit
    wr(0, 16'h09FF); wr(1, 16'h0B00);
    ramp(1'b1, 20, 40, -1, "R5 rise unchanged before commit", "R5 fall unchanged before commit");
    ramp(1'b0, 20, 40, -1, "R5 rise unchanged before commit", "R5 fall unchanged before commit");

    wr(2, 16'h0000);
    ramp(1'b0, 20, 40, -1, "R6 committed rise", "R6 committed fall");
    ramp(1'b1, 20, 40, -1, "R6 committed rise", "R6 committed fall");

    // Commit between t1 and t2: current ramp keeps old values
    wr(0, 16'h0200); wr(1, 16'h0400);
    ramp(1'b0, 20, 40, 5, "R7 rise keeps in-use value", "R7 fall keeps in-use value");
    ramp(1'b0, 20, 40, -1, "R7 rise new value next ramp", "R7 fall new value next ramp");

    // Rise and fall expire together
    wr(0, 16'h1E00); wr(1, 16'h0A00); wr(2, 16'h0000);
    ramp(1'b0, 20, 40, -1, "R8 coincident expiry", "R8 coincident expiry");

    // Largest delay
    wr(0, 16'hFF00); wr(1, 16'h0100); wr(2, 16'h0000);
    ramp(1'b0, 300, 320, -1, "R9 max rise delay", "R9 fall after long high");

    repeat (10) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R9 scoreboard: %0d expectations left, expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule